// File: doc/BRIEF.md
# Power Management Timer and Event Controller

This block keeps a free-running power-management count, which software reads as a 24-bit timer. A sticky event status word, an event enable word and a sleep control word sit beside the count. Two external events set status bits: a power-button press and a real-time-clock alarm. A timer overflow bit is set once the count reaches a moving threshold. A registered, level-sensitive interrupt is driven high while any status bit that can interrupt is set and has its enable bit set. The control word also has a suspend strobe. When software writes that strobe with a sleep type, the block issues either a soft power-off request or a suspend-to-RAM request, each as a one-cycle pulse.

Software reaches the registers through a byte-addressed port with 32-bit data and byte enables. A single I/O enable input can shut the whole port off. The count advances once for each clock in which `tick_en` is high. The integrator drives `tick_en` at the 3.579545 MHz rate. The timer width is the parameter `TMR_W`, which defaults to 24. The count is held `TMR_W+8` bits wide inside the block, so the threshold compare stays correct when the visible timer rolls over.

Top module: `pm_evt_ctrl`

## Requirements
- R1: `reg_addr[5:2]` selects a word and `reg_addr[1:0]` must be 0. Word 0 reads `{enable, status}`. Word 1 reads `{16'hFFFF, control}`. Word 2 reads the timer, zero-extended. Any other word, or an access with `reg_addr[1:0]` nonzero, reads 32'hFFFFFFFF. The read data is combinational while `reg_rd` is high and is all ones otherwise.
- R2: The count increases by one on each clock edge at which `tick_en` is high. The timer read returns only the low `TMR_W` bits of the count.
- R3: `pwrbtn_evt` sets status bit 8 and `rtc_evt` sets status bit 10. Only status bits 0, 8, 10 and 15 exist; the others read 0. A write to status clears each bit that is written as 1. An event that arrives in the same cycle as that write wins, and its bit stays set.
- R4: `irq_level` goes high one clock after the status AND enable AND 16'h0521 term becomes nonzero. It goes low one clock after that term becomes zero.
- R5: Writes change only the bytes whose `reg_be` bit is set. Bytes 1:0 of word 0 are status and bytes 3:2 are enable.
- R6: Status bit 0 is set whenever the internal count is at or above the threshold. After reset the threshold is 2^TMR_W-1.
- R7: A status write that clears a set bit 0 moves the threshold to (count + 2^(TMR_W-1)) with its low TMR_W-1 bits cleared. In that cycle the bit stays clear.
- R8: Control bit 13 is a strobe and always reads 0. A write with byte 1 enabled and bit 13 set decodes the sleep type in bits 12:10. Sleep type 0 pulses `soft_off_req` for one cycle.
- R9: Sleep type 1 sets status bits 15 and 8 and pulses `str_req` for one cycle. Any other sleep type has no effect beyond storing the control bits.
- R10: While `io_en` is low, writes change nothing and reads return 32'hFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_en | input | 1 | Register port enable |
| tick_en | input | 1 | Count advance strobe |
| pwrbtn_evt | input | 1 | Power-button event |
| rtc_evt | input | 1 | RTC alarm event |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 6 | Byte address |
| reg_be | input | 4 | Byte enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| irq_level | output | 1 | Level interrupt |
| soft_off_req | output | 1 | Soft power-off pulse |
| str_req | output | 1 | Suspend-to-RAM pulse |

## Verification
A wrong threshold shows at the ports in one of two ways. The overflow status bit may rise one tick early or late at the rollover points. It may also come back immediately after it is cleared. The bench ticks the count to one step before and exactly at each boundary to expose both cases. A stale status or enable bit shows as `irq_level` changing one cycle off, so the bench samples that output both before and after its one-cycle latency. Sleep decode errors show at once as a missing or wrong request pulse, or as stray status bits in the next read.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

    localparam int BUS_W = 32;
    localparam int REG_W = 16;
    localparam int ADDR_W = 6;

    // status bit positions
    localparam int ST_TMR  = 0;
    localparam int ST_PWR  = 8;
    localparam int ST_RTC  = 10;
    localparam int ST_WAKE = 15;

    localparam logic [REG_W-1:0] IRQ_MASK = 16'h0521;
    localparam logic [REG_W-1:0] ST_IMPL  = 16'h8501;

    // control fields
    localparam int CT_SUSP = 13;

    // word indices
    localparam logic [3:0] WD_EVT = 4'd0;
    localparam logic [3:0] WD_CTL = 4'd1;
    localparam logic [3:0] WD_TMR = 4'd2;

    typedef enum logic [1:0] {
        SLP_NONE = 2'd0,
        SLP_OFF  = 2'd1,
        SLP_RAM  = 2'd2
    } slp_act_e;

    typedef struct packed {
        logic [REG_W-1:0] sts;
        logic [REG_W-1:0] en;
        logic [REG_W-1:0] ctl;
    } pm_regs_t;

    typedef struct packed {
        logic             sts_wr;
        logic             en_wr;
        logic             ctl_wr;
        logic [3:0]       be;
        logic [BUS_W-1:0] data;
    } wr_req_t;

    function automatic slp_act_e decode_sleep(input logic strobe, input logic [2:0] typ);
        if (!strobe)
            return SLP_NONE;
        case (typ)
            3'd0:    return SLP_OFF;
            3'd1:    return SLP_RAM;
            default: return SLP_NONE;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] byte_merge(input logic [REG_W-1:0] old_v,
                                                    input logic [REG_W-1:0] new_v,
                                                    input logic [1:0] be);
        logic [REG_W-1:0] r;
        r = old_v;
        for (int b = 0; b < 2; b++)
            if (be[b])
                r[b*8 +: 8] = new_v[b*8 +: 8];
        return r;
    endfunction

endpackage

// File: rtl/pm_tick_timer.sv
module pm_tick_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (tick)
            count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
    import pm_evt_pkg::*;
#(
    parameter int TMR_W = 24,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_req_t          wr,
    input  logic             pwr_evt,
    input  logic             rtc_evt,
    input  logic [CNT_W-1:0] count,
    output pm_regs_t         regs,
    output logic [CNT_W-1:0] thr,
    output logic             irq,
    output logic             soft_off,
    output logic             str
);
    localparam logic [CNT_W-1:0] HALF    = CNT_W'(1) << (TMR_W - 1);
    localparam logic [CNT_W-1:0] THR_RST = (CNT_W'(1) << TMR_W) - CNT_W'(1);

    logic [REG_W-1:0] clr_v, set_v, sts_d, en_d, ctl_d, ctl_w;
    logic             rearm, ovf_hit;
    slp_act_e         act;

    always_comb begin
        clr_v = '0;
        if (wr.sts_wr) begin
            if (wr.be[0]) clr_v[7:0]  = wr.data[7:0];
            if (wr.be[1]) clr_v[15:8] = wr.data[15:8];
        end
        rearm   = clr_v[ST_TMR] & regs.sts[ST_TMR];
        ovf_hit = (count >= thr) && !rearm;
        act     = decode_sleep(wr.ctl_wr && wr.be[1] && wr.data[CT_SUSP], wr.data[12:10]);

        set_v          = '0;
        set_v[ST_TMR]  = ovf_hit;
        set_v[ST_PWR]  = pwr_evt || (act == SLP_RAM);
        set_v[ST_RTC]  = rtc_evt;
        set_v[ST_WAKE] = (act == SLP_RAM);

        sts_d = ((regs.sts & ~clr_v) | set_v) & ST_IMPL;
        en_d  = wr.en_wr ? byte_merge(regs.en, wr.data[31:16], wr.be[3:2]) : regs.en;
        ctl_w = wr.data[15:0];
        ctl_w[CT_SUSP] = 1'b0;
        ctl_d = wr.ctl_wr ? byte_merge(regs.ctl, ctl_w, wr.be[1:0]) : regs.ctl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs     <= '0;
            thr      <= THR_RST;
            irq      <= 1'b0;
            soft_off <= 1'b0;
            str      <= 1'b0;
        end else begin
            regs.sts <= sts_d;
            regs.en  <= en_d;
            regs.ctl <= ctl_d;
            if (rearm)
                thr <= (count + HALF) & ~(HALF - CNT_W'(1));
            irq      <= |(regs.sts & regs.en & IRQ_MASK);
            soft_off <= (act == SLP_OFF);
            str      <= (act == SLP_RAM);
        end
    end
endmodule

// File: rtl/pm_reg_read.sv
module pm_reg_read
    import pm_evt_pkg::*;
#(
    parameter int TMR_W = 24
) (
    input  logic             rd,
    input  logic             ok,
    input  logic [3:0]       word,
    input  pm_regs_t         regs,
    input  logic [TMR_W-1:0] tmr,
    output logic [BUS_W-1:0] rdata
);
    always_comb begin
        rdata = '1;
        if (rd && ok) begin
            case (word)
                WD_EVT:  rdata = {regs.en, regs.sts};
                WD_CTL:  rdata = {16'hFFFF, regs.ctl};
                WD_TMR:  rdata = BUS_W'(tmr);
                default: rdata = '1;
            endcase
        end
    end
endmodule

// File: rtl/pm_evt_ctrl.sv
module pm_evt_ctrl
    import pm_evt_pkg::*;
#(
    parameter int TMR_W = 24,
    parameter int CNT_W = TMR_W + 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        io_en,
    input  logic        tick_en,
    input  logic        pwrbtn_evt,
    input  logic        rtc_evt,
    input  logic        reg_rd,
    input  logic        reg_wr,
    input  logic [5:0]  reg_addr,
    input  logic [3:0]  reg_be,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_level,
    output logic        soft_off_req,
    output logic        str_req
);
    logic             acc_ok;
    logic [3:0]       word;
    wr_req_t          wr;
    pm_regs_t         regs;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] thr;
    logic [REG_W-1:0] sts_w, en_w;

    assign acc_ok = io_en && (reg_addr[1:0] == 2'b00);
    assign word   = reg_addr[5:2];

    always_comb begin
        wr.be     = reg_be;
        wr.data   = reg_wdata;
        wr.sts_wr = reg_wr && acc_ok && (word == WD_EVT) && |reg_be[1:0];
        wr.en_wr  = reg_wr && acc_ok && (word == WD_EVT) && |reg_be[3:2];
        wr.ctl_wr = reg_wr && acc_ok && (word == WD_CTL) && |reg_be[1:0];
    end

    pm_tick_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst(rst), .tick(tick_en), .count(count)
    );

    pm_evt_regs #(.TMR_W(TMR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr(wr), .pwr_evt(pwrbtn_evt), .rtc_evt(rtc_evt),
        .count(count), .regs(regs), .thr(thr), .irq(irq_level),
        .soft_off(soft_off_req), .str(str_req)
    );

    pm_reg_read #(.TMR_W(TMR_W)) u_rd (
        .rd(reg_rd), .ok(acc_ok), .word(word), .regs(regs),
        .tmr(count[TMR_W-1:0]), .rdata(reg_rdata)
    );

    assign sts_w = regs.sts;
    assign en_w  = regs.en;
endmodule

// File: rtl/pm_evt_ctrl_chk.sv
module pm_evt_ctrl_chk
    import pm_evt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             io_en,
    input logic             reg_wr,
    input logic [31:0]      reg_rdata,
    input logic             irq_level,
    input logic             soft_off_req,
    input logic             str_req,
    input logic [15:0]      sts,
    input logic [15:0]      en,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] thr
);
    // R4
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq_level == $past(|(sts & en & IRQ_MASK))));

    // R8
    one_req_chk: assert property (@(posedge clk) disable iff (rst)
        !(soft_off_req && str_req));

    // R9
    ram_marks_chk: assert property (@(posedge clk) disable iff (rst)
        str_req |-> (sts[ST_WAKE] && sts[ST_PWR]));

    // R6
    ovf_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sts[ST_TMR]) |-> $past(count >= thr));

    // R10
    gated_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (!io_en && reg_wr) |=> $stable(en));

    // R10
    gated_rd_chk: assert property (@(posedge clk) disable iff (rst)
        !io_en |-> (reg_rdata == 32'hFFFF_FFFF));
endmodule

bind pm_evt_ctrl pm_evt_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .io_en(io_en), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
    .irq_level(irq_level), .soft_off_req(soft_off_req), .str_req(str_req),
    .sts(sts_w), .en(en_w), .count(count), .thr(thr)
);

// File: tb/pm_evt_ctrl_tb.sv
`timescale 1ns/1ps
module pm_evt_ctrl_tb;
    localparam int TW = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_en = 1'b1, tick_en = 1'b0, pwrbtn_evt = 1'b0, rtc_evt = 1'b0;
    logic        reg_rd = 1'b0, reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_level, soft_off_req, str_req;

    int n_chk = 0, n_bad = 0;
    logic so_s, str_s;
    logic [31:0] rv;

    always #10 clk = ~clk;

    pm_evt_ctrl #(.TMR_W(TW)) u_dut (
        .clk(clk), .rst(rst), .io_en(io_en), .tick_en(tick_en),
        .pwrbtn_evt(pwrbtn_evt), .rtc_evt(rtc_evt), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_level(irq_level),
        .soft_off_req(soft_off_req), .str_req(str_req)
    );

    // {op(1=write), addr, be, data, expected read}
    localparam logic [75:0] VEC [0:14] = '{
        {2'd0, 6'h00, 4'h0, 32'h0, 32'h0000_0000},
        {2'd0, 6'h04, 4'h0, 32'h0, 32'hFFFF_0000},
        {2'd0, 6'h08, 4'h0, 32'h0, 32'h0000_0000},
        {2'd0, 6'h0C, 4'h0, 32'h0, 32'hFFFF_FFFF},
        {2'd0, 6'h3C, 4'h0, 32'h0, 32'hFFFF_FFFF},
        {2'd1, 6'h00, 4'hC, 32'h05A1_0000, 32'h0},
        {2'd0, 6'h00, 4'h0, 32'h0, 32'h05A1_0000},
        {2'd1, 6'h00, 4'h4, 32'h00FF_0000, 32'h0},
        {2'd0, 6'h00, 4'h0, 32'h0, 32'h05FF_0000},
        {2'd1, 6'h04, 4'h3, 32'h0000_0C07, 32'h0},
        {2'd0, 6'h04, 4'h0, 32'h0, 32'hFFFF_0C07},
        {2'd1, 6'h04, 4'h3, 32'h0000_3C00, 32'h0},
        {2'd0, 6'h04, 4'h0, 32'h0, 32'hFFFF_1C00},
        {2'd1, 6'h00, 4'hC, 32'h0, 32'h0},
        {2'd0, 6'h01, 4'h0, 32'h0, 32'hFFFF_FFFF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
        @(negedge clk);
        so_s = soft_off_req; str_s = str_req;
        reg_wr = 1'b0; reg_be = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic pulse_pwr();
        @(negedge clk); pwrbtn_evt = 1'b1;
        @(negedge clk); pwrbtn_evt = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got hung expected done");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("reset irq", {31'd0, irq_level}, 32'd0);
        chk("reset req", {30'd0, soft_off_req, str_req}, 32'd0);

        // R1 R5 table walk
        for (int i = 0; i < 15; i++) begin
            if (VEC[i][75:74] == 2'd1)
                wr(VEC[i][73:68], VEC[i][67:64], VEC[i][63:32]);
            else begin
                rd(VEC[i][73:68], rv);
                chk($sformatf("R1/R5 table[%0d]", i), rv, VEC[i][31:0]);
            end
        end

        // R3 R4 power button
        wr(6'h00, 4'hC, 32'h0100_0000);
        pulse_pwr();
        chk("R4 latency", {31'd0, irq_level}, 32'd0);
        @(negedge clk);
        chk("R4 irq high", {31'd0, irq_level}, 32'd1);
        rd(6'h00, rv);
        chk("R3 pwr sts", rv, 32'h0100_0100);
        wr(6'h00, 4'h2, 32'h0000_0100);
        chk("R4 hold", {31'd0, irq_level}, 32'd1);
        @(negedge clk);
        chk("R4 irq low", {31'd0, irq_level}, 32'd0);

        // R4 masked rtc, then enabled; R3 set-wins
        wr(6'h00, 4'hC, 32'h0);
        @(negedge clk); rtc_evt = 1'b1;
        @(negedge clk); rtc_evt = 1'b0;
        repeat (2) @(negedge clk);
        chk("R4 masked", {31'd0, irq_level}, 32'd0);
        rd(6'h00, rv);
        chk("R3 rtc sts", rv, 32'h0000_0400);
        rtc_evt = 1'b1;
        wr(6'h00, 4'h2, 32'h0000_0400);
        rtc_evt = 1'b0;
        rd(6'h00, rv);
        chk("R3 set wins", rv, 32'h0000_0400);
        wr(6'h00, 4'h2, 32'h0000_0400);
        rd(6'h00, rv);
        chk("R3 w1c", rv, 32'h0000_0000);

        // R2 R6 R7 timer
        wr(6'h00, 4'hC, 32'h0001_0000);
        ticks(1022);
        @(negedge clk);
        rd(6'h08, rv);
        chk("R2 count", rv, 32'd1022);
        rd(6'h00, rv);
        chk("R6 below", rv, 32'h0001_0000);
        ticks(1);
        @(negedge clk);
        rd(6'h00, rv);
        chk("R6 at thr", rv, 32'h0001_0001);
        @(negedge clk);
        chk("R4 tmr irq", {31'd0, irq_level}, 32'd1);
        wr(6'h00, 4'h1, 32'h1);
        @(negedge clk);
        rd(6'h00, rv);
        chk("R7 rearm clear", rv, 32'h0001_0000);
        ticks(1);
        @(negedge clk);
        rd(6'h00, rv);
        chk("R7 boundary 1024", rv, 32'h0001_0001);
        rd(6'h08, rv);
        chk("R2 rollover", rv, 32'd0);
        wr(6'h00, 4'h1, 32'h1);
        ticks(511);
        @(negedge clk);
        rd(6'h00, rv);
        chk("R7 below 1536", rv, 32'h0001_0000);
        ticks(1);
        @(negedge clk);
        rd(6'h00, rv);
        chk("R7 at 1536", rv, 32'h0001_0001);
        rd(6'h08, rv);
        chk("R2 low bits", rv, 32'd512);
        wr(6'h00, 4'hF, 32'h0000_0001);

        // R9 suspend to RAM
        wr(6'h04, 4'h2, 32'h0000_2400);
        chk("R9 pulse", {30'd0, so_s, str_s}, 32'd1);
        @(negedge clk);
        chk("R9 one cycle", {31'd0, str_req}, 32'd0);
        rd(6'h00, rv);
        chk("R9 sts", rv, 32'h0000_8100);
        rd(6'h04, rv);
        chk("R8 strobe drop", rv, 32'hFFFF_0400);
        wr(6'h00, 4'h3, 32'h0000_8100);

        // R8 soft off
        wr(6'h04, 4'h3, 32'h0000_2000);
        chk("R8 soft off", {30'd0, so_s, str_s}, 32'd2);
        // R9 other sleep type
        wr(6'h04, 4'h3, 32'h0000_2800);
        chk("R9 other type", {30'd0, so_s, str_s}, 32'd0);
        rd(6'h00, rv);
        chk("R9 no sts", rv, 32'h0000_0000);
        // R8 strobe needs byte 1
        wr(6'h04, 4'h1, 32'h0000_2000);
        chk("R8 be gated", {30'd0, so_s, str_s}, 32'd0);
        rd(6'h04, rv);
        chk("R8 ctl", rv, 32'hFFFF_0800);

        // R10 port disabled
        io_en = 1'b0;
        rd(6'h00, rv);
        chk("R10 read ones", rv, 32'hFFFF_FFFF);
        wr(6'h00, 4'hC, 32'hFFFF_0000);
        wr(6'h04, 4'h3, 32'h0000_2000);
        chk("R10 no pulse", {30'd0, so_s, str_s}, 32'd0);
        io_en = 1'b1;
        rd(6'h00, rv);
        chk("R10 en kept", rv, 32'h0000_0000);
        rd(6'h04, rv);
        chk("R10 ctl kept", rv, 32'hFFFF_0800);

        summary();
    end
endmodule